// File: doc/BRIEF.md
# Configurable Pin Bank with Interrupt and Wakeup Logic

This block controls a bank of general-purpose pins, one to sixteen of them. Software sets up each pin through a simple word-addressed register bus. A pin can be a plain sampled input. It can also be an output, driven push-pull or open-drain, whose value comes either from a register bit or from a sigma-delta pulse-density generator belonging to that pin. On the pad side the block drives a value, an output enable, and pull-up and pull-down requests. It receives the raw pad level in return.

Every input passes through a two-flop synchronizer. The synchronized level is readable by software. It feeds a per-pin interrupt detector, and the mode field picks the trigger: rising edge, falling edge, either edge, low level or high level. Status bits are sticky and are cleared by writing 1. The interrupt line is the OR of the enabled status bits. A separate wakeup line is purely level-sensitive, with its own enable and polarity per pin, so it does not depend on the interrupt path.

A small hold state machine prepares the pads for power-down. It has two states. LIVE is the reset state, and in it the pads follow the registers. FROZEN holds the values captured on entry. The transition LIVE to FROZEN happens on the first clock after the freeze bit of the hold register reads 1, and the outputs are captured at that edge. The transition FROZEN to LIVE happens on the first clock after the freeze bit reads 0. While FROZEN, the float bit forces every output enable low.

Top module: `pinbank_ctrl`

Register map (word addresses): 0x00 output value, 0x01 drive enable, 0x02 open-drain select, 0x03 sigma-delta source select, 0x04 pull-up, 0x05 pull-down, 0x06 synchronized input (read-only), 0x07 interrupt status (write 1 to clear), 0x08 interrupt enable, 0x09 wakeup enable, 0x0A wakeup polarity, 0x0B hold (bit 0 freeze, bit 1 float). Per-pin words sit at 0x20 + pin: bits [3:0] hold the interrupt mode and bits [15:8] the sigma-delta duty. In every bank-wide register, bit n belongs to pin n.

## Requirements
- R1: After reset every register reads 0, and pad_oe, pad_out, irq and wake are all 0.
- R2: With source select 0 and open-drain 0, pad_oe equals the drive-enable bit and pad_out equals the output-value bit.
- R3: With open-drain 1, pad_out is 0 and pad_oe is 1 only when the drive enable is 1 and the selected value is 0.
- R4: With source select 1, the pin's value is the carry out of an 8-bit accumulator that adds the duty field (bits [15:8] of word 0x20+pin) each cycle, so over any 256 consecutive cycles the value is 1 exactly duty times.
- R5: Register 0x06 returns the pad input levels after a two-flop synchronizer, and these are visible no later than three cycles after the pad changes.
- R6: Mode field values: 0 off, 1 rising edge, 2 falling edge, 3 both edges, 4 low level, 5 high level, 6 to 15 off. A detected event sets a sticky status bit in 0x07. A level mode sets the bit again on every cycle the level is present.
- R7: Writing 1 to a bit of 0x07 clears it, and writing 0 leaves it unchanged. If an event occurs in the same cycle as the clear, the event wins.
- R8: irq is 1 exactly when some status bit is 1 and its enable bit in 0x08 is also 1.
- R9: wake is 1 when any pin with its 0x09 bit set has a synchronized level equal to its 0x0A polarity bit. This is independent of the interrupt status and enables.
- R10: While FROZEN, pad_out and pad_oe keep the values captured on entry, and register writes do not change them. Returning to LIVE makes the pads follow the registers again.
- R11: While FROZEN with the float bit set, every pad_oe bit is 0.
- R12: pad_pu follows 0x04. pad_pd follows 0x05, except that it is 0 wherever the pull-up bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe, data valid the next cycle |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pad_in | input | NPINS | Raw pad levels |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| pad_pu | output | NPINS | Pull-up requests |
| pad_pd | output | NPINS | Pull-down requests |
| irq | output | 1 | Interrupt request to the CPU |
| wake | output | 1 | Level-sensitive wakeup request |

## Verification
The bench works on a four-pin bank and sweeps every combination of drive enable, value and open-drain select, all sixteen input patterns, and all eight low mode codes through a rise, clear, fall, clear sequence. A detector that lost the stickiness, let a clear beat a present level, or fired edge modes on levels would show a wrong status word at one of those four points. For several duty values the bench counts the sigma-delta ones over exactly 256 cycles. A wrong carry, or an accumulator that is one bit short, gives a count that differs from the duty. The hold test rewrites the output registers while frozen and sets the float bit. A capture taken on the wrong edge, or leakage from live registers, shows up on the pads.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int unsigned MODE_W    = 4;
    localparam int unsigned DUTY_LSB  = 8;

    localparam int unsigned A_OUT     = 'h00;
    localparam int unsigned A_DRV     = 'h01;
    localparam int unsigned A_OD      = 'h02;
    localparam int unsigned A_SRC     = 'h03;
    localparam int unsigned A_PU      = 'h04;
    localparam int unsigned A_PD      = 'h05;
    localparam int unsigned A_IN      = 'h06;
    localparam int unsigned A_STAT    = 'h07;
    localparam int unsigned A_IEN     = 'h08;
    localparam int unsigned A_WEN     = 'h09;
    localparam int unsigned A_WPOL    = 'h0A;
    localparam int unsigned A_HOLD    = 'h0B;
    localparam int unsigned A_CFG     = 'h20;

    typedef enum logic [MODE_W-1:0] {
        IM_OFF  = 4'd0,
        IM_RISE = 4'd1,
        IM_FALL = 4'd2,
        IM_BOTH = 4'd3,
        IM_LOW  = 4'd4,
        IM_HIGH = 4'd5
    } irq_mode_e;

    typedef enum logic {
        HS_LIVE   = 1'b0,
        HS_FROZEN = 1'b1
    } hold_state_e;

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] safe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            safe_q <= '0;
        end else begin
            meta_q <= d_i;
            safe_q <= meta_q;
        end
    end

    assign q_o = safe_q;

endmodule

// File: rtl/pinbank_sdm.sv
module pinbank_sdm #(
    parameter int unsigned ACC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] duty_i,
    output logic             bit_o
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    assign sum   = {1'b0, acc_q} + {1'b0, duty_i};
    assign bit_o = sum[ACC_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= sum[ACC_W-1:0];
    end

    // R4: a zero duty never produces a one
    assert_zero_duty_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_i == '0) |-> !bit_o);

    // R4: the accumulator only wraps when a carry is reported
    assert_wrap_carries_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q < $past(acc_q) && $stable(duty_i)) |-> $past(bit_o));

endmodule

// File: rtl/pinbank_edge.sv
module pinbank_edge
    import pinbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              sin_i,
    input  logic              clr_i,
    output logic              stat_o
);

    irq_mode_e md;
    logic      sin_d;
    logic      hit;
    logic      stat_q;

    assign md = irq_mode_e'(mode_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sin_d <= 1'b0;
        else        sin_d <= sin_i;
    end

    always_comb begin
        hit = 1'b0;
        unique case (md)
            IM_RISE: hit = sin_i & ~sin_d;
            IM_FALL: hit = ~sin_i & sin_d;
            IM_BOTH: hit = sin_i ^ sin_d;
            IM_LOW:  hit = ~sin_i;
            IM_HIGH: hit = sin_i;
            default: hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     stat_q <= 1'b0;
        else if (hit)   stat_q <= 1'b1;
        else if (clr_i) stat_q <= 1'b0;
    end

    assign stat_o = stat_q;

    // R6: a present high level always leaves the status set
    assert_level_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (md == IM_HIGH && sin_i) |=> stat_o);

    // R6: a rising edge in rising mode sets the status
    assert_rise_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (md == IM_RISE && sin_i && !sin_d) |=> stat_o);

    // R7: an idle pin that was set stays set until cleared
    assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o && !clr_i) |=> stat_o);

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int unsigned NPINS  = 16,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_pu,
    output logic [NPINS-1:0]  pad_pd,
    output logic              irq,
    output logic              wake
);

    localparam int unsigned DUTY_MSB = DUTY_LSB + DUTY_W - 1;

    // bank-wide registers
    logic [NPINS-1:0] out_q, drv_q, od_q, src_q, pu_q, pd_q;
    logic [NPINS-1:0] ien_q, wen_q, wpol_q;
    logic [1:0]       hold_q;

    // per-pin derived signals
    logic [NPINS-1:0]             sin;
    logic [NPINS-1:0]             stat;
    logic [NPINS-1:0]             sd_bit;
    logic [NPINS-1:0]             live_out, live_oe;
    logic [NPINS-1:0][DATA_W-1:0] cfg_word;

    // hold state machine
    hold_state_e      st_q, st_d;
    logic [NPINS-1:0] cap_out, cap_oe;

    logic             stat_wr;
    logic [DATA_W-1:0] rd_mux;

    assign stat_wr = bus_we && (bus_addr == ADDR_W'(A_STAT));

    pinbank_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pad_in),
        .q_o   (sin)
    );

    // bank-wide register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            drv_q  <= '0;
            od_q   <= '0;
            src_q  <= '0;
            pu_q   <= '0;
            pd_q   <= '0;
            ien_q  <= '0;
            wen_q  <= '0;
            wpol_q <= '0;
            hold_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == ADDR_W'(A_OUT))  out_q  <= bus_wdata[NPINS-1:0];
            if (bus_addr == ADDR_W'(A_DRV))  drv_q  <= bus_wdata[NPINS-1:0];
            if (bus_addr == ADDR_W'(A_OD))   od_q   <= bus_wdata[NPINS-1:0];
            if (bus_addr == ADDR_W'(A_SRC))  src_q  <= bus_wdata[NPINS-1:0];
            if (bus_addr == ADDR_W'(A_PU))   pu_q   <= bus_wdata[NPINS-1:0];
            if (bus_addr == ADDR_W'(A_PD))   pd_q   <= bus_wdata[NPINS-1:0];
            if (bus_addr == ADDR_W'(A_IEN))  ien_q  <= bus_wdata[NPINS-1:0];
            if (bus_addr == ADDR_W'(A_WEN))  wen_q  <= bus_wdata[NPINS-1:0];
            if (bus_addr == ADDR_W'(A_WPOL)) wpol_q <= bus_wdata[NPINS-1:0];
            if (bus_addr == ADDR_W'(A_HOLD)) hold_q <= bus_wdata[1:0];
        end
    end

    // per-pin configuration, detector and generator
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic              cfg_hit;
        logic [MODE_W-1:0] mode_q;
        logic [DUTY_W-1:0] duty_q;
        logic              val;

        assign cfg_hit = bus_we && (bus_addr == ADDR_W'(A_CFG + i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mode_q <= '0;
                duty_q <= '0;
            end else if (cfg_hit) begin
                mode_q <= bus_wdata[MODE_W-1:0];
                duty_q <= bus_wdata[DUTY_MSB:DUTY_LSB];
            end
        end

        assign cfg_word[i] = DATA_W'({duty_q, {(DUTY_LSB - MODE_W){1'b0}}, mode_q});

        pinbank_edge u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode_i (mode_q),
            .sin_i  (sin[i]),
            .clr_i  (stat_wr && bus_wdata[i]),
            .stat_o (stat[i])
        );

        pinbank_sdm #(.ACC_W(DUTY_W)) u_sdm (
            .clk    (clk),
            .rst_n  (rst_n),
            .duty_i (duty_q),
            .bit_o  (sd_bit[i])
        );

        assign val         = src_q[i] ? sd_bit[i] : out_q[i];
        assign live_out[i] = od_q[i] ? 1'b0 : val;
        assign live_oe[i]  = drv_q[i] & (od_q[i] ? ~val : 1'b1);
    end

    // hold state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= HS_LIVE;
        else        st_q <= st_d;
    end

    // hold next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HS_LIVE:   if (hold_q[0])  st_d = HS_FROZEN;
            HS_FROZEN: if (!hold_q[0]) st_d = HS_LIVE;
            default:   st_d = HS_LIVE;
        endcase
    end

    // capture on entry to FROZEN
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_out <= '0;
            cap_oe  <= '0;
        end else if (st_q == HS_LIVE && st_d == HS_FROZEN) begin
            cap_out <= live_out;
            cap_oe  <= live_oe;
        end
    end

    // pad outputs per state
    always_comb begin
        pad_out = live_out;
        pad_oe  = live_oe;
        unique case (st_q)
            HS_LIVE: begin
                pad_out = live_out;
                pad_oe  = live_oe;
            end
            HS_FROZEN: begin
                pad_out = cap_out;
                pad_oe  = hold_q[1] ? '0 : cap_oe;
            end
            default: begin
                pad_out = live_out;
                pad_oe  = live_oe;
            end
        endcase
    end

    assign pad_pu = pu_q;
    assign pad_pd = pd_q & ~pu_q;
    assign irq    = |(stat & ien_q);
    assign wake   = |(wen_q & ~(sin ^ wpol_q));

    // read path
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            ADDR_W'(A_OUT):  rd_mux = DATA_W'(out_q);
            ADDR_W'(A_DRV):  rd_mux = DATA_W'(drv_q);
            ADDR_W'(A_OD):   rd_mux = DATA_W'(od_q);
            ADDR_W'(A_SRC):  rd_mux = DATA_W'(src_q);
            ADDR_W'(A_PU):   rd_mux = DATA_W'(pu_q);
            ADDR_W'(A_PD):   rd_mux = DATA_W'(pd_q);
            ADDR_W'(A_IN):   rd_mux = DATA_W'(sin);
            ADDR_W'(A_STAT): rd_mux = DATA_W'(stat);
            ADDR_W'(A_IEN):  rd_mux = DATA_W'(ien_q);
            ADDR_W'(A_WEN):  rd_mux = DATA_W'(wen_q);
            ADDR_W'(A_WPOL): rd_mux = DATA_W'(wpol_q);
            ADDR_W'(A_HOLD): rd_mux = DATA_W'(hold_q);
            default:         rd_mux = '0;
        endcase
        for (int k = 0; k < NPINS; k++) begin
            if (bus_addr == ADDR_W'(A_CFG + k)) rd_mux = cfg_word[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux;
    end

    // R3: open-drain pins never drive a one
    assert_od_no_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HS_LIVE) |-> ((pad_out & od_q) == '0));

    // R3: an open-drain pin with a register value of one is released
    assert_od_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HS_LIVE) |-> ((pad_oe & od_q & out_q & ~src_q) == '0));

    // R10: pad values stay put for as long as the bank is frozen
    assert_frozen_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HS_FROZEN && $past(st_q) == HS_FROZEN) |-> $stable(pad_out));

    // R10: output enables stay put while frozen and the float bit is unchanged
    assert_frozen_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HS_FROZEN && $past(st_q) == HS_FROZEN && $stable(hold_q)) |-> $stable(pad_oe));

    // R8: no interrupt without an enabled pending status
    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);

endmodule

// File: tb/pinbank_ctrl_tb.sv
`timescale 1ns/1ps
module pinbank_ctrl_tb_top;

    localparam int unsigned NP = 4;
    localparam int unsigned AW = 6;
    localparam int unsigned DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe, pad_pu, pad_pd;
    logic          irq, wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pinbank_ctrl #(.NPINS(NP), .ADDR_W(AW), .DATA_W(DW), .DUTY_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .irq(irq), .wake(wake)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = AW'(a);
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [3:0]  e_oe, e_out, e_stat;
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        for (int a = 0; a < 12; a++) begin
            rd(a, r);
            chk($sformatf("R1 reg %0d", a), r, 32'h0);
        end
        rd('h20, r);
        chk("R1 cfg0", r, 32'h0);
        chk("R1 pad_oe", {28'h0, pad_oe}, 32'h0);
        chk("R1 pad_out", {28'h0, pad_out}, 32'h0);
        chk("R1 irq/wake", {30'h0, irq, wake}, 32'h0);

        // R2 / R3 output sweep
        for (int c = 0; c < 8; c++) begin
            logic v, en, od;
            v = c[0]; en = c[1]; od = c[2];
            wr('h00, v ? 32'hF : 32'h0);
            wr('h01, en ? 32'hF : 32'h0);
            wr('h02, od ? 32'hF : 32'h0);
            tick(1);
            e_oe  = (en && (!od || !v)) ? 4'hF : 4'h0;
            e_out = (!od && v) ? 4'hF : 4'h0;
            chk($sformatf("%s oe c=%0d", od ? "R3" : "R2", c), {28'h0, pad_oe}, {28'h0, e_oe});
            chk($sformatf("%s out c=%0d", od ? "R3" : "R2", c), {28'h0, pad_out}, {28'h0, e_out});
        end
        // mixed per-pin pattern: R2 and R3 side by side
        wr('h00, 32'b0110);
        wr('h01, 32'b1111);
        wr('h02, 32'b0011);
        tick(1);
        chk("R3 mixed oe", {28'h0, pad_oe}, 32'b1101);
        chk("R2 mixed out", {28'h0, pad_out}, 32'b0100);
        wr('h02, 32'h0);

        // R4 sigma-delta duty sweep
        wr('h03, 32'hF);
        wr('h01, 32'hF);
        for (int t = 0; t < 5; t++) begin
            int duty [4];
            int cnt [4];
            duty[0] = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 37 : (t == 3) ? 128 : 255;
            duty[1] = 255 - duty[0];
            duty[2] = (duty[0] * 3 + 7) % 256;
            duty[3] = (duty[0] + 200) % 256;
            for (int p = 0; p < 4; p++) begin
                wr('h20 + p, 32'(duty[p]) << 8);
                cnt[p] = 0;
            end
            for (int k = 0; k < 256; k++) begin
                @(negedge clk);
                for (int p = 0; p < 4; p++) cnt[p] += int'(pad_out[p]);
            end
            for (int p = 0; p < 4; p++)
                chk($sformatf("R4 duty=%0d pin%0d", duty[p], p), 32'(cnt[p]), 32'(duty[p]));
        end
        for (int p = 0; p < 4; p++) wr('h20 + p, 32'h0);
        wr('h03, 32'h0);
        wr('h01, 32'h0);

        // R5 input sampling and R9 wakeup sweep
        wr('h09, 32'b1011);
        wr('h0A, 32'b0101);
        for (int v = 0; v < 16; v++) begin
            logic [3:0] m;
            pad_in = 4'(v);
            tick(3);
            m = 4'b1011 & ~(4'(v) ^ 4'b0101);
            chk($sformatf("R9 wake in=%0h", v), {31'h0, wake}, {31'h0, (m != 0)});
            rd('h06, r);
            chk($sformatf("R5 sample in=%0h", v), r, 32'(v));
        end
        // R9: wake ignores interrupt enables and status
        wr('h09, 32'h0);
        tick(1);
        chk("R9 wake disabled", {31'h0, wake}, 32'h0);
        pad_in = 4'h0;
        tick(4);

        // R6 / R7 / R8 interrupt mode sweep
        wr('h08, 32'hF);
        for (int m = 0; m < 8; m++) begin
            for (int p = 0; p < 4; p++) wr('h20 + p, 32'(m));
            tick(3);
            wr('h07, 32'hF);
            tick(2);
            pad_in = 4'hF;
            tick(4);
            e_stat = (m == 1 || m == 3 || m == 4 || m == 5) ? 4'hF : 4'h0;
            rd('h07, r);
            chk($sformatf("R6 mode=%0d after rise", m), r, {28'h0, e_stat});
            chk($sformatf("R8 irq mode=%0d", m), {31'h0, irq}, {31'h0, (e_stat != 0)});
            wr('h07, 32'hF);
            tick(2);
            e_stat = (m == 5) ? 4'hF : 4'h0;
            rd('h07, r);
            chk($sformatf("R7 mode=%0d clear while high", m), r, {28'h0, e_stat});
            pad_in = 4'h0;
            tick(4);
            e_stat = (m == 2 || m == 3 || m == 4 || m == 5) ? 4'hF : 4'h0;
            rd('h07, r);
            chk($sformatf("R6 mode=%0d after fall", m), r, {28'h0, e_stat});
            wr('h07, 32'h0);
            rd('h07, r);
            chk($sformatf("R7 mode=%0d write zero", m), r, {28'h0, e_stat});
            wr('h08, 32'h0);
            tick(1);
            chk($sformatf("R8 irq masked mode=%0d", m), {31'h0, irq}, 32'h0);
            wr('h08, 32'hF);
            wr('h07, 32'hF);
            tick(2);
            e_stat = (m == 4) ? 4'hF : 4'h0;
            rd('h07, r);
            chk($sformatf("R7 mode=%0d clear while low", m), r, {28'h0, e_stat});
        end
        // R7 partial clear: only written bits drop
        for (int p = 0; p < 4; p++) wr('h20 + p, 32'h1);
        pad_in = 4'hF;
        tick(4);
        wr('h07, 32'b0101);
        rd('h07, r);
        chk("R7 partial clear", r, 32'b1010);
        for (int p = 0; p < 4; p++) wr('h20 + p, 32'h0);
        wr('h07, 32'hF);
        wr('h08, 32'h0);
        pad_in = 4'h0;

        // R10 / R11 hold
        wr('h00, 32'b1010);
        wr('h01, 32'hF);
        wr('h0B, 32'h1);
        tick(2);
        wr('h00, 32'b0101);
        wr('h01, 32'b0011);
        tick(2);
        chk("R10 frozen out", {28'h0, pad_out}, 32'b1010);
        chk("R10 frozen oe", {28'h0, pad_oe}, 32'hF);
        wr('h0B, 32'h3);
        tick(1);
        chk("R11 float oe", {28'h0, pad_oe}, 32'h0);
        chk("R11 float out", {28'h0, pad_out}, 32'b1010);
        wr('h0B, 32'h0);
        tick(2);
        chk("R10 released out", {28'h0, pad_out}, 32'b0101);
        chk("R10 released oe", {28'h0, pad_oe}, 32'b0011);

        // R12 pulls
        wr('h04, 32'b0011);
        wr('h05, 32'b0110);
        tick(1);
        chk("R12 pull-up", {28'h0, pad_pu}, 32'b0011);
        chk("R12 pull-down", {28'h0, pad_pd}, 32'b0100);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule